// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block converts single read and write requests from a clocked on-chip port into strobe sequences for an external byte-wide asynchronous static RAM with a 17-bit word address. It drives active-low chip select, write strobe and output gate lines, a registered address bus, and the data bus as a separate output value, output-enable and input value. The pad ring combines these three into the shared bidirectional pins.

Each access is a fixed series of phases. A write has an address setup phase, a write strobe pulse and a short hold phase. The write ends when the write strobe rises while chip select is still low. A read has an access phase followed by a turnaround phase in which the memory releases the bus. The length of each phase is a whole number of clock cycles. It is worked out at elaboration from nanosecond limits and the clock period as ceil(ns / period) + 1. The default limits are 0 ns address setup, a strobe pulse of max(7, 5, 8) ns, 0 ns hold, a 10 ns read access and a 5 ns turnaround. At an 8 ns clock these give 1, 2, 1, 3 and 2 cycles.

The request side uses valid/ready. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the controller is idle. The requester must hold `req_valid`, `req_write`, `req_addr` and `req_wdata` steady until the transfer. While the controller is busy these inputs are ignored. Read data has no back-pressure: it appears as a one-cycle `rd_valid` pulse that the consumer must take.

Top module: `asram_ctrl`

## Requirements
- R1: While idle and after a synchronous active-high reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after that edge until the access's last phase ends. Request inputs that change while busy or while `req_valid` is 0 start no access and do not alter the bus.
- R3: A write (`req_write`=1) holds `mem_ce_n`=0 for 4 cycles. During the 1 setup cycle `mem_we_n`=1. During the next 2 cycles `mem_we_n`=0. During the 1 hold cycle `mem_we_n`=1 again. `mem_oe_n` stays 1 throughout.
- R4: `mem_dq_oe` is 1 in every cycle of a write and 0 in every other cycle, so it is never 1 while `mem_oe_n` is 0. `mem_dq_out` carries the accepted write byte for the whole write.
- R5: A read (`req_write`=0) holds `mem_ce_n`=0 and `mem_oe_n`=0 with `mem_we_n`=1 for 3 cycles.
- R6: The bus value present on the last read access cycle is captured. It appears on `rd_data` with `rd_valid`=1 for exactly the one following cycle. `rd_data` then holds that value.
- R7: After a read, all strobes are 1 and `mem_dq_oe` is 0 for 2 turnaround cycles before `req_ready` returns to 1.
- R8: `mem_addr` equals the accepted request address and is stable throughout every cycle in which `mem_ce_n` is 0.
- R9: Reset asserted during an access ends it at the next edge. No `rd_valid` pulse follows, and the controller is idle.
- R10: A byte written and later read back at the same address is returned unchanged, including at addresses 0 and 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Captured read byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Value to drive on the data pins |
| mem_dq_oe | output | 1 | Data pin driver enable |
| mem_dq_in | input | 8 | Value sampled from the data pins |

## Verification
The hardest situations to reach are a request arriving on the same edge a turnaround or hold phase ends, and a reset landing in the middle of a read access. The stimulus keeps `req_valid` high through a chain of mixed reads and writes, so every acceptance falls on the first idle cycle. It also raises reset one cycle into a read. Meanwhile, the request inputs are scrambled while busy with `req_valid` low, to show the held address and data are untouched. The memory model returns unknown data until output gate and chip select have been low for two cycles. A capture that comes too early therefore shows up as a data mismatch.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WSETUP = 3'd1,
    PH_WPULSE = 3'd2,
    PH_WHOLD  = 3'd3,
    PH_RACC   = 3'd4,
    PH_RTURN  = 3'd5
  } phase_t;

  // whole cycles covering a nanosecond limit, plus one margin cycle
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns + 1;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_sequencer.sv
module asram_sequencer
  import asram_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 3,
  parameter int TURN_CYC   = 2,
  parameter int CW         = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          expired,
  output phase_t        phase,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          capture
);
  localparam logic [CW-1:0] L_SETUP  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_PULSE  = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] L_HOLD   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] L_ACCESS = CW'(ACCESS_CYC - 1);
  localparam logic [CW-1:0] L_TURN   = CW'(TURN_CYC - 1);

  phase_t phase_q, phase_d;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (req_valid) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (req_write) begin
          phase_d = PH_WSETUP;
          tmr_val = L_SETUP;
        end else begin
          phase_d = PH_RACC;
          tmr_val = L_ACCESS;
        end
      end
      PH_WSETUP: if (expired) begin
        phase_d  = PH_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = L_PULSE;
      end
      PH_WPULSE: if (expired) begin
        phase_d  = PH_WHOLD;
        tmr_load = 1'b1;
        tmr_val  = L_HOLD;
      end
      PH_WHOLD: if (expired) phase_d = PH_IDLE;
      PH_RACC: if (expired) begin
        phase_d  = PH_RTURN;
        tmr_load = 1'b1;
        tmr_val  = L_TURN;
        capture  = 1'b1;
      end
      PH_RTURN: if (expired) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= mem_dq_in;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_ASETUP_NS   = 0,
  parameter int T_WPULSE_NS   = 7,
  parameter int T_DSETUP_NS   = 5,
  parameter int T_AVALID_NS   = 8,
  parameter int T_WHOLD_NS    = 0,
  parameter int T_ACCESS_NS   = 10,
  parameter int T_TURN_NS     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int SETUP_CYC  = ns_to_cycles(T_ASETUP_NS, CLK_PERIOD_NS);
  localparam int PULSE_CYC  = ns_to_cycles(max3(T_WPULSE_NS, T_DSETUP_NS, T_AVALID_NS), CLK_PERIOD_NS);
  localparam int HOLD_CYC   = ns_to_cycles(T_WHOLD_NS, CLK_PERIOD_NS);
  localparam int ACCESS_CYC = ns_to_cycles(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int TURN_CYC   = ns_to_cycles(T_TURN_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC    = max3(max3(SETUP_CYC, PULSE_CYC, HOLD_CYC), ACCESS_CYC, TURN_CYC);
  localparam int CW         = $clog2(MAX_CYC) + 1;

  phase_t        phase;
  logic          tmr_load, expired, accept, capture;
  logic [CW-1:0] tmr_val;

  asram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  asram_sequencer #(
    .SETUP_CYC  (SETUP_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .ACCESS_CYC (ACCESS_CYC),
    .TURN_CYC   (TURN_CYC),
    .CW         (CW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .expired   (expired),
    .phase     (phase),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .capture   (capture)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  // strobes decoded from the phase register only
  always_comb begin
    req_ready = (phase == PH_IDLE);
    mem_ce_n  = (phase == PH_IDLE) || (phase == PH_RTURN);
    mem_we_n  = (phase != PH_WPULSE);
    mem_oe_n  = (phase != PH_RACC);
    mem_dq_oe = (phase == PH_WSETUP) || (phase == PH_WPULSE) || (phase == PH_WHOLD);
  end
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));

  // R5
  read_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
  localparam int PER = 8;
  // phase lengths from the requirements: ceil(ns/PER)+1
  localparam int S  = (0 + PER - 1) / PER + 1;
  localparam int WP = (8 + PER - 1) / PER + 1;
  localparam int H  = (0 + PER - 1) / PER + 1;
  localparam int RA = (10 + PER - 1) / PER + 1;
  localparam int T  = (5 + PER - 1) / PER + 1;

  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rd_data, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;

  int checks = 0, errors = 0;
  bit enable_cmp = 0;

  always #(PER/2) clk = ~clk;

  asram_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // ---------------- behavioural memory ----------------
  logic [7:0] sram [int];
  int rd_age = 0;
  logic prev_we_n = 1;

  function automatic logic [7:0] dflt(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] sram_rd(input logic [16:0] a);
    return sram.exists(int'(a)) ? sram[int'(a)] : dflt(a);
  endfunction

  assign mem_dq_in = (rd_age >= 2) ? sram_rd(mem_addr) : 8'hxx;

  always @(negedge clk) begin
    if (prev_we_n == 1'b0 && mem_we_n == 1'b1 && mem_ce_n == 1'b0)
      sram[int'(mem_addr)] = mem_dq_out;
    prev_we_n = mem_we_n;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age = rd_age + 1;
    else rd_age = 0;
  end

  // ---------------- reference model ----------------
  logic [7:0] shadow [int];
  int kind = 0, tick = 0;          // kind: 0 idle, 1 write, 2 read
  logic [16:0] exp_addr = '0;
  logic [7:0]  exp_wdata = '0, exp_rdata = '0, last_rd = '0;

  function automatic logic [7:0] shadow_rd(input logic [16:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic e_ce, e_we, e_oe, e_oe_dq, e_rv;
    int len;
    if (enable_cmp) begin
      e_ce = 1; e_we = 1; e_oe = 1; e_oe_dq = 0; e_rv = 0;
      if (kind == 1) begin
        e_ce = 0; e_oe_dq = 1;
        if (tick >= S && tick < S + WP) e_we = 0;
      end else if (kind == 2) begin
        if (tick < RA) begin e_ce = 0; e_oe = 0; end
        if (tick == RA) e_rv = 1;
      end
      chk(kind == 0 ? "R1" : "R2", "req_ready", req_ready, kind == 0);
      chk(kind == 1 ? "R3" : "R5", "mem_ce_n", mem_ce_n, e_ce);
      chk("R3", "mem_we_n", mem_we_n, e_we);
      chk(kind == 2 && tick >= RA ? "R7" : "R5", "mem_oe_n", mem_oe_n, e_oe);
      chk("R4", "mem_dq_oe", mem_dq_oe, e_oe_dq);
      chk("R6", "rd_valid", rd_valid, e_rv);
      if (!e_ce) chk("R8", "mem_addr", mem_addr, exp_addr);
      if (e_oe_dq) chk("R4", "mem_dq_out", mem_dq_out, exp_wdata);
      if (e_rv) begin
        chk("R10", "rd_data", rd_data, exp_rdata);
        last_rd = exp_rdata;
      end else if (kind == 0) chk("R6", "rd_data held", rd_data, last_rd);
    end
    // advance to the next cycle
    len = (kind == 1) ? S + WP + H : RA + T;
    if (rst) begin
      kind = 0; tick = 0; last_rd = '0;
    end else if (kind == 0) begin
      if (req_valid) begin
        kind = req_write ? 1 : 2; tick = 0;
        exp_addr = req_addr;
        if (req_write) begin
          exp_wdata = req_wdata;
          shadow[int'(req_addr)] = req_wdata;
        end else exp_rdata = shadow_rd(req_addr);
      end
    end else begin
      tick++;
      if (tick == len) kind = 0;
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d, input bit drop);
    bit taken;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    taken = 0;
    while (!taken) begin
      @(negedge clk); taken = req_ready;
      @(posedge clk); #2;
    end
    if (drop) req_valid = 0;
  endtask

  task automatic idle_cycles(input int n);
    req_valid = 0;
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic scramble_while_busy();
    // R2: inputs change with valid low during an access
    req_valid = 0;
    repeat (3) begin
      req_write = ~req_write; req_addr = req_addr ^ 17'h1ABCD; req_wdata = ~req_wdata;
      @(posedge clk); #2;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "reset ce_n", mem_ce_n, 1);
    chk("R1", "reset we_n", mem_we_n, 1);
    chk("R1", "reset oe_n", mem_oe_n, 1);
    chk("R1", "reset dq_oe", mem_dq_oe, 0);
    chk("R1", "reset ready", req_ready, 1);
    chk("R1", "reset rd_valid", rd_valid, 0);
    enable_cmp = 1;
    @(posedge clk); #2;
    idle_cycles(2);

    // R3 R10 basic write then read
    issue(1, 17'h00123, 8'hA7, 1);
    scramble_while_busy();
    idle_cycles(3);
    issue(0, 17'h00123, 8'h00, 1);
    scramble_while_busy();
    idle_cycles(4);

    // R10 boundary addresses and data
    issue(1, 17'h00000, 8'hFF, 1);
    idle_cycles(4);
    issue(1, 17'h1FFFF, 8'h00, 1);
    idle_cycles(4);
    issue(0, 17'h00000, 8'h00, 1);
    idle_cycles(5);
    issue(0, 17'h1FFFF, 8'h00, 1);
    idle_cycles(5);
    // unwritten address returns memory contents
    issue(0, 17'h0BEEF, 8'h00, 1);
    idle_cycles(5);

    // R2 R7 back-to-back with valid held high throughout
    for (int i = 0; i < 24; i++) begin
      issue((i % 3) != 2, 17'(i * 4097 + 5), 8'(i * 37 + 1), 0);
    end
    for (int i = 0; i < 12; i++) begin
      issue(0, 17'(i * 4097 + 5), 8'h00, 0);
    end
    idle_cycles(8);

    // R9: reset one cycle into a read
    issue(0, 17'h00123, 8'h00, 1);
    @(posedge clk); #0;
    #2 rst = 1;
    @(posedge clk); #2 rst = 0;
    @(negedge clk);
    chk("R9", "ready after reset", req_ready, 1);
    chk("R9", "ce_n after reset", mem_ce_n, 1);
    chk("R9", "oe_n after reset", mem_oe_n, 1);
    chk("R9", "no rd_valid", rd_valid, 0);
    @(posedge clk); #2;
    idle_cycles(3);
    issue(0, 17'h00123, 8'h00, 1);
    idle_cycles(6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule